// File: doc/BRIEF.md
# Descriptor submission portal queue

This block sits behind a memory-mapped submission window. Several requesters each present a 512-bit work descriptor together with an address and a mode flag. The flag is 0 for a plain posted write and 1 for a write that expects a status reply. A fixed-priority arbiter takes at most one descriptor per cycle. In that same cycle the block either writes the whole descriptor into queue storage or turns it away, so there is no staging register a later write could overwrite. A consumer pops descriptors from the head of the queue in arrival order.

The queue runs in one of two configurations. In dedicated mode, every write is accepted while there is room and is discarded silently once the queue is full. In shared mode, status writes get a one-bit reply in the cycle of the grant, where 0 means accepted and 1 means retry. Posted writes in shared mode are always discarded. Address bits 13:12 select one of four portals. Portal 0 needs one free entry. Portals 1 to 3 need at least a programmable number of free entries. Every other address bit is ignored. Three counters track accepted, dropped and retried descriptors.

Top module: `desc_portal_queue`

## Requirements
- R1: At most one requester is granted per cycle. The grant goes to the lowest-numbered requester with a valid descriptor, combinationally in that cycle. Requesters that are not granted see ready 0 and their descriptor is neither counted nor stored.
- R2: Only address bits 13:12 (the portal number) affect handling. Bits 11:0 and any bits above 13 have no effect.
- R3: In dedicated mode (shared_i = 0), a granted descriptor is accepted when there is room and dropped otherwise. No response is ever raised. A drop increments drop_cnt_o. The queue never holds more than DEPTH entries.
- R4: In shared mode, a granted status write (req_status_i = 1) raises resp_valid_o for that requester in the grant cycle. resp_retry_o is 0 when the descriptor is accepted and 1 when it is refused. Each refusal increments retry_cnt_o.
- R5: In shared mode, a granted posted write (req_status_i = 0) is always dropped without a response and increments drop_cnt_o.
- R6: Free entries are counted as DEPTH minus the fill, plus one when a pop happens in the same cycle. Portal 0 needs at least 1 free entry. Portals 1 to 3 need at least max(thresh_i, 1) free entries.
- R7: When the queue is full, a pop in the same cycle as a grant makes room, and the descriptor is accepted.
- R8: Accepted descriptors leave in acceptance order. head_valid_o and head_data_o reflect a write or pop from the next cycle on. A pop while empty has no effect.
- R9: acc_cnt_o increments by one for each accepted descriptor.
- R10: After reset the queue is empty and all three counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shared_i | input | 1 | 1 selects shared mode, 0 selects dedicated mode |
| thresh_i | input | CW | Free-entry threshold for portals 1 to 3 |
| req_valid_i | input | N | Descriptor present, one bit per requester |
| req_addr_i | input | N x AW | Submission address per requester |
| req_data_i | input | N x DW | Descriptor payload per requester |
| req_status_i | input | N | 1 = status write, 0 = posted write |
| req_ready_o | output | N | Grant, one-hot or zero |
| resp_valid_o | output | N | Status reply present |
| resp_retry_o | output | N | Status reply value, 1 = retry |
| pop_i | input | 1 | Consumer removes the head entry |
| head_valid_o | output | 1 | Queue not empty |
| head_data_o | output | DW | Oldest stored descriptor |
| acc_cnt_o | output | SW | Accepted descriptors |
| drop_cnt_o | output | SW | Dropped descriptors |
| retry_cnt_o | output | SW | Refused status writes |

## Verification
A fill count that drifts from the true occupancy shows up at the ports within one cycle. A status write then gets a retry while the queue still has room, or a dedicated write is counted as a drop instead of an accept. A wrong read or write pointer shows up as a head payload that differs from the bench's reference queue in the cycle after the affected push or pop. A wrong priority or portal decode changes req_ready_o or resp_retry_o combinationally, in the very cycle of the request.

// File: rtl/dpq_pkg.sv
package dpq_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_ACCEPT = 2'd1,
    ACT_DROP   = 2'd2,
    ACT_RETRY  = 2'd3
  } act_e;
endpackage

// File: rtl/dpq_arb.sv
module dpq_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpq_decide.sv
module dpq_decide
  import dpq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          win_valid_i,
  input  logic [1:0]    win_portal_i,
  input  logic          win_status_i,
  input  logic          shared_i,
  input  logic [CW-1:0] thresh_i,
  input  logic [CW-1:0] fill_i,
  input  logic          pop_eff_i,
  output act_e          act_o
);
  localparam logic [CW:0] DEPTH_L = (CW+1)'(DEPTH);

  logic [CW:0] free_ent;
  logic [CW:0] need;
  logic        room;

  always_comb begin
    free_ent = DEPTH_L - {1'b0, fill_i} + {{CW{1'b0}}, pop_eff_i};
    if (win_portal_i == 2'd0 || thresh_i == '0) need = (CW+1)'(1);
    else                                         need = {1'b0, thresh_i};
    room = (free_ent >= need);
  end

  always_comb begin
    act_o = ACT_NONE;
    if (win_valid_i) begin
      if (!shared_i)          act_o = room ? ACT_ACCEPT : ACT_DROP;
      else if (!win_status_i) act_o = ACT_DROP;
      else                    act_o = room ? ACT_ACCEPT : ACT_RETRY;
    end
  end
endmodule

// File: rtl/dpq_fifo.sv
module dpq_fifo #(
  parameter int DW    = 512,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] fill_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      fill_q <= fill_q + CW'(1);
      else if (!push_i && pop_i) fill_q <= fill_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  assign head_o = mem_q[rd_q];
  assign fill_o = fill_q;
endmodule

// File: rtl/desc_portal_queue.sv
module desc_portal_queue
  import dpq_pkg::*;
#(
  parameter int N     = 4,
  parameter int AW    = 16,
  parameter int DW    = 512,
  parameter int DEPTH = 8,
  parameter int SW    = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shared_i,
  input  logic [CW-1:0]        thresh_i,
  input  logic [N-1:0]         req_valid_i,
  input  logic [N-1:0][AW-1:0] req_addr_i,
  input  logic [N-1:0][DW-1:0] req_data_i,
  input  logic [N-1:0]         req_status_i,
  output logic [N-1:0]         req_ready_o,
  output logic [N-1:0]         resp_valid_o,
  output logic [N-1:0]         resp_retry_o,
  input  logic                 pop_i,
  output logic                 head_valid_o,
  output logic [DW-1:0]        head_data_o,
  output logic [SW-1:0]        acc_cnt_o,
  output logic [SW-1:0]        drop_cnt_o,
  output logic [SW-1:0]        retry_cnt_o
);
  logic [N-1:0]  grant;
  logic          win_valid;
  logic [1:0]    win_portal;
  logic          win_status;
  logic [DW-1:0] win_data;
  logic [CW-1:0] fill;
  logic          pop_eff;
  act_e          act;
  logic [SW-1:0] acc_q, drop_q, retry_q;

  dpq_arb #(.N(N)) u_arb (
    .valid_i (req_valid_i),
    .grant_o (grant)
  );

  // winner mux, only portal bits of the address matter
  always_comb begin
    win_portal = '0;
    win_status = 1'b0;
    win_data   = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        win_portal = req_addr_i[i][13:12];
        win_status = req_status_i[i];
        win_data   = req_data_i[i];
      end
    end
  end

  assign win_valid = |grant;
  assign pop_eff   = pop_i && (fill != '0);

  dpq_decide #(.DEPTH(DEPTH)) u_decide (
    .win_valid_i  (win_valid),
    .win_portal_i (win_portal),
    .win_status_i (win_status),
    .shared_i     (shared_i),
    .thresh_i     (thresh_i),
    .fill_i       (fill),
    .pop_eff_i    (pop_eff),
    .act_o        (act)
  );

  dpq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (act == ACT_ACCEPT),
    .din_i  (win_data),
    .pop_i  (pop_eff),
    .head_o (head_data_o),
    .fill_o (fill)
  );

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_resp
      assign resp_valid_o[g] = grant[g] && shared_i && req_status_i[g] &&
                               (act == ACT_ACCEPT || act == ACT_RETRY);
      assign resp_retry_o[g] = grant[g] && (act == ACT_RETRY);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      drop_q  <= '0;
      retry_q <= '0;
    end else begin
      case (act)
        ACT_ACCEPT: acc_q   <= acc_q + SW'(1);
        ACT_DROP:   drop_q  <= drop_q + SW'(1);
        ACT_RETRY:  retry_q <= retry_q + SW'(1);
        default: ;
      endcase
    end
  end

  assign req_ready_o  = grant;
  assign head_valid_o = (fill != '0);
  assign acc_cnt_o    = acc_q;
  assign drop_cnt_o   = drop_q;
  assign retry_cnt_o  = retry_q;
endmodule

// File: rtl/dpq_checker.sv
module dpq_checker #(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  parameter int SW    = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          shared_i,
  input logic          pop_i,
  input logic [N-1:0]  req_valid_i,
  input logic [N-1:0]  req_status_i,
  input logic [N-1:0]  req_ready_o,
  input logic [N-1:0]  resp_valid_o,
  input logic [N-1:0]  resp_retry_o,
  input logic [CW-1:0] fill,
  input logic [SW-1:0] acc_cnt_o
);
  p_one_grant_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_prio_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i[0] |-> req_ready_o[0]);
  p_grant_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= CW'(DEPTH));
  p_silent_ded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shared_i |-> resp_valid_o == '0);
  p_resp_granted_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((resp_valid_o & ~req_ready_o) == '0) && ((resp_retry_o & ~resp_valid_o) == '0));
  p_retry_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared_i && fill == CW'(DEPTH) && !pop_i && |(req_ready_o & req_status_i))
      |-> |resp_retry_o);
  p_acc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (acc_cnt_o == $past(acc_cnt_o)) || (acc_cnt_o == $past(acc_cnt_o) + SW'(1)));
endmodule

bind desc_portal_queue dpq_checker #(.N(N), .DEPTH(DEPTH), .SW(SW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .shared_i     (shared_i),
  .pop_i        (pop_i),
  .req_valid_i  (req_valid_i),
  .req_status_i (req_status_i),
  .req_ready_o  (req_ready_o),
  .resp_valid_o (resp_valid_o),
  .resp_retry_o (resp_retry_o),
  .fill         (fill),
  .acc_cnt_o    (acc_cnt_o)
);

// File: tb/desc_portal_queue_tb.sv
`timescale 1ns/1ps
module desc_portal_queue_tb;
  localparam int N = 4, AW = 16, DW = 512, DEPTH = 8, SW = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                 sh = 1'b0, pp = 1'b0;
  logic [CW-1:0]        th = '0;
  logic [N-1:0]         v = '0, st = '0;
  logic [N-1:0][AW-1:0] a = '0;
  logic [N-1:0][DW-1:0] d = '0;
  logic [N-1:0]         rdy, rv, rr;
  logic                 hv;
  logic [DW-1:0]        hd;
  logic [SW-1:0]        acc, drp, rty;

  desc_portal_queue #(.N(N), .AW(AW), .DW(DW), .DEPTH(DEPTH), .SW(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .shared_i(sh), .thresh_i(th),
    .req_valid_i(v), .req_addr_i(a), .req_data_i(d), .req_status_i(st),
    .req_ready_o(rdy), .resp_valid_o(rv), .resp_retry_o(rr), .pop_i(pp),
    .head_valid_o(hv), .head_data_o(hd),
    .acc_cnt_o(acc), .drop_cnt_o(drp), .retry_cnt_o(rty));

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] mq[$];
  int e_acc = 0, e_drop = 0, e_retry = 0;

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] x;
    for (int k = 0; k < DW / 32; k++) x[k*32 +: 32] = $urandom;
    return x;
  endfunction

  function automatic logic [AW-1:0] mk_addr(int portal, int off);
    logic [AW-1:0] x;
    x = AW'($urandom);
    x[13:12] = 2'(portal);
    x[11:6]  = 6'(off);
    return x;
  endfunction

  task automatic set_one(int i, int portal, int off, logic status);
    v = '0; v[i] = 1'b1;
    a[i] = mk_addr(portal, off);
    d[i] = rnd_data();
    st[i] = status;
  endtask

  // called at a negedge with inputs already set
  task automatic cycle(string tag);
    int sz, fr, need, w;
    bit pe, room;
    logic [N-1:0] eg, erv, err;
    int act; // 0 none 1 acc 2 drop 3 retry
    #1;
    sz = mq.size();
    pe = pp && sz > 0;
    fr = DEPTH - sz + (pe ? 1 : 0);
    w = -1;
    for (int i = 0; i < N; i++) if (v[i] && w < 0) w = i;
    eg = '0; erv = '0; err = '0; act = 0;
    if (w >= 0) begin
      eg[w] = 1'b1;
      need = (a[w][13:12] == 2'd0 || th == '0) ? 1 : int'(th);
      room = fr >= need;
      if (!sh) act = room ? 1 : 2;
      else if (!st[w]) act = 2;
      else begin
        act = room ? 1 : 3;
        erv[w] = 1'b1;
        err[w] = !room;
      end
    end
    chk("R1", {tag, " ready"}, 64'(rdy), 64'(eg));
    chk(sh ? "R4" : "R3", {tag, " resp_valid"}, 64'(rv), 64'(erv));
    chk(act == 3 ? "R4" : "R6", {tag, " resp_retry"}, 64'(rr), 64'(err));
    @(posedge clk);
    if (pe) void'(mq.pop_front());
    if (act == 1) begin mq.push_back(d[w]); e_acc++; end
    if (act == 2) e_drop++;
    if (act == 3) e_retry++;
    #1;
    chk("R8", {tag, " head_valid"}, 64'(hv), 64'(mq.size() > 0));
    if (mq.size() > 0) begin
      chk("R8", {tag, " head low"}, hd[63:0], mq[0][63:0]);
      chk("R8", {tag, " head full"}, 64'(hd === mq[0]), 64'd1);
    end
    chk("R9", {tag, " acc_cnt"}, 64'(acc), 64'(e_acc));
    chk(sh ? "R5" : "R3", {tag, " drop_cnt"}, 64'(drp), 64'(e_drop));
    chk("R4", {tag, " retry_cnt"}, 64'(rty), 64'(e_retry));
    @(negedge clk);
  endtask

  task automatic drain();
    v = '0; pp = 1'b1;
    while (mq.size() > 0) cycle("drain");
    pp = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0001));
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset head_valid", 64'(hv), 64'd0);
    chk("R10", "reset acc", 64'(acc), 64'd0);
    chk("R10", "reset drop", 64'(drp), 64'd0);
    chk("R10", "reset retry", 64'(rty), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R8: pop on empty queue has no effect
    pp = 1'b1; cycle("R8 pop empty"); pp = 1'b0;

    // R2 R3: dedicated fill via portal 0 with different page offsets, then overflow
    sh = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      set_one(k % N, 0, k * 7, k[0]);
      cycle("R2 offsets");
    end
    set_one(2, 0, 63, 1'b1); cycle("R3 full drop");
    set_one(0, 0, 0, 1'b0);  cycle("R3 full drop");
    chk("R3", "two drops counted", 64'(drp), 64'd2);
    chk("R3", "silent drop", 64'(rv), 64'd0);

    // R7: full queue, pop together with a grant makes room
    set_one(1, 0, 5, 1'b0); pp = 1'b1; cycle("R7 pop+accept"); pp = 1'b0;
    chk("R7", "accepted at full", 64'(acc), 64'(DEPTH + 1));

    // R4 R5: shared, full, no pop
    sh = 1'b1;
    set_one(3, 0, 9, 1'b1); cycle("R4 retry full");
    set_one(3, 0, 9, 1'b0); cycle("R5 posted shared");
    chk("R4", "retry counted", 64'(rty), 64'd1);
    drain();
    set_one(0, 0, 0, 1'b0); cycle("R5 posted empty");
    set_one(0, 3, 1, 1'b1); cycle("R4 accept empty");

    // R6: threshold on portals 1-3
    drain();
    th = CW'(5);
    for (int k = 0; k < 4; k++) begin set_one(0, 0, k, 1'b1); cycle("R6 fill"); end
    set_one(1, 2, 0, 1'b1); cycle("R6 below thresh");
    chk("R6", "portal2 refused free=4 thresh=5", 64'(rty), 64'd2);
    set_one(1, 0, 0, 1'b1); cycle("R6 portal0 ok");
    drain();
    set_one(2, 1, 33, 1'b1); cycle("R6 thresh met");
    sh = 1'b0;
    for (int k = 0; k < 3; k++) begin set_one(0, 0, k, 1'b0); cycle("R6 ded fill"); end
    set_one(0, 1, 0, 1'b0); cycle("R6 ded below");
    drain();

    // R1: simultaneous requesters
    v = 4'b1110; for (int i = 0; i < N; i++) begin a[i] = mk_addr(0, i); d[i] = rnd_data(); end
    cycle("R1 prio");
    v = 4'b1111; cycle("R1 prio all");
    drain(); th = '0;

    // random
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) begin sh = $urandom_range(0, 1); th = CW'($urandom_range(0, DEPTH + 1)); end
      for (int i = 0; i < N; i++) begin
        v[i]  = ($urandom_range(0, 99) < 30);
        a[i]  = mk_addr($urandom_range(0, 3), $urandom_range(0, 63));
        d[i]  = rnd_data();
        st[i] = $urandom_range(0, 1);
      end
      pp = ($urandom_range(0, 99) < 40);
      cycle("rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule